// File: doc/BRIEF.md
# Circular Trace Capture Buffer

This block records a stream of 32-bit trace words into an internal RAM that wraps around, so it always holds the most recent window of activity. Software arms capture through a small register bus. Words arrive on a valid/ready input and are written one per cycle while capture runs. A trigger pulse marks the event of interest. After the trigger, the block keeps exactly a programmed number of further words and then stalls the input. The stored window therefore straddles the trigger.

Capture can also end in two other ways. Software can clear the enable bit. Software can also request a flush, which clears itself one cycle later and, if the stop-on-flush option is set, ends capture. When capture ends, the block parks its read pointer on the oldest stored word. Software then drains the buffer one word per access of the read-data register. Once the buffer is empty, that register returns an all-ones marker.

Top module: `trace_capture_buf`

## Requirements
- R1: After reset, STATUS (word address 1) reads 0x4, WRPTR (address 6) and RDPTR (address 5) read 0, RDATA (address 7) reads 0xFFFFFFFF, and `tr_ready` is low.
- R2: SIZE (address 2) reads the capacity in 32-bit words (DEPTH). DEVID (address 9) carries the memory width code in bits 10:8: 2, 3, 4 or 5 for 1, 2, 4 or 8 lanes of 32 bits.
- R3: Writing CTRL (address 0) with bit 0 set while disabled clears the write pointer, the wrap flag, the trigger flag and any earlier stop. Writing bit 0 as 0 ends capture. `tr_ready` is high only while capture runs in mode 0.
- R4: Each accepted word is stored at the write pointer, and the pointer then advances by one. Going past DEPTH-1 returns it to 0 and sets STATUS bit 0 (wrapped), which stays set until the next arm.
- R5: A trigger pulse during capture sets STATUS bit 1 and loads TRGCNT (address 4). Exactly that many further words are accepted, after which `tr_ready` stays low. With TRGCNT = 0, capture stops at once. A trigger outside capture is ignored.
- R6: Writing FLUSH (address 8) with bit 6 set makes bit 6 read 1 until the next clock edge, after which it reads 0. If bit 12 of the same write is set, capture stops when the flush completes. If bit 12 is clear, capture continues.
- R7: STATUS bit 2 (ready) reads 1 only when capture is not running and no stop or flush is still being processed.
- R8: When capture stops, RDPTR is loaded with the oldest stored word: the write pointer if the wrap flag is set, otherwise 0.
- R9: Each read of RDATA returns the next stored word, oldest first. The read pointer advances and wraps at DEPTH. After every stored word has been returned, RDATA reads 0xFFFFFFFF and the pointer holds.
- R10: MODE (address 3) value 0 selects circular capture. Any other value keeps `tr_ready` low, so nothing is stored. Writes to MODE while enabled are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 4 | Register word address |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (advances the drain on RDATA) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational from the address) |
| tr_valid | input | 1 | Trace word valid |
| tr_ready | output | 1 | Trace word accepted this cycle when high with valid |
| tr_data | input | 32 | Trace word |
| trig_in | input | 1 | Trigger event pulse |

## Verification
The hardest state to reach is a stop that falls after the buffer has wrapped, with a trigger somewhere inside the retained window. In that state the drain has to start mid-RAM, cross address zero and end exactly at the write pointer. The bench reaches it with rounds of seeded random length (up to about two and a half buffers), a random trigger position and a random post-trigger count, including zero. A reference model in the bench tracks which words must survive. Directed cases cover exact-capacity fills, flushes with and without stop, and mode writes made while enabled.

// File: rtl/tcb_pkg.sv
package tcb_pkg;
  localparam int unsigned WORD_W = 32;

  typedef enum logic [3:0] {
    RA_CTRL   = 4'd0,
    RA_STAT   = 4'd1,
    RA_SIZE   = 4'd2,
    RA_MODE   = 4'd3,
    RA_TRGCNT = 4'd4,
    RA_RDPTR  = 4'd5,
    RA_WRPTR  = 4'd6,
    RA_RDATA  = 4'd7,
    RA_FLUSH  = 4'd8,
    RA_DEVID  = 4'd9
  } reg_addr_e;

  localparam int unsigned FLUSH_REQ_BIT  = 6;
  localparam int unsigned FLUSH_STOP_BIT = 12;
  localparam logic [WORD_W-1:0] EMPTY_WORD = '1;

  // width code reported for a memory of 'lanes' 32-bit lanes
  function automatic logic [2:0] width_code(int unsigned lanes);
    case (lanes)
      1:       return 3'd2;
      2:       return 3'd3;
      4:       return 3'd4;
      default: return 3'd5;
    endcase
  endfunction

  // address of the oldest stored word
  function automatic int unsigned oldest_index(logic wrapped, int unsigned wp);
    return wrapped ? wp : 0;
  endfunction

  // number of stored words
  function automatic int unsigned held_words(logic wrapped, int unsigned wp,
                                             int unsigned depth);
    return wrapped ? depth : wp;
  endfunction
endpackage

// File: rtl/tcb_ctrl_regs.sv
module tcb_ctrl_regs
  import tcb_pkg::*;
#(
  parameter int unsigned CW = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [3:0]        addr,
  input  logic [WORD_W-1:0] wdata,
  output logic              en,
  output logic [1:0]        mode,
  output logic [CW-1:0]     trg_cnt,
  output logic              arm,
  output logic              flush_busy,
  output logic              stop_on_flush
);
  logic wr_ctrl, wr_mode, wr_trg, wr_flush;
  logic wdata_unused;

  assign wr_ctrl  = wr_en && (addr == RA_CTRL);
  assign wr_mode  = wr_en && (addr == RA_MODE);
  assign wr_trg   = wr_en && (addr == RA_TRGCNT);
  assign wr_flush = wr_en && (addr == RA_FLUSH);
  assign arm      = wr_ctrl && wdata[0] && !en;
  assign wdata_unused = ^wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en            <= 1'b0;
      mode          <= 2'd0;
      trg_cnt       <= '0;
      flush_busy    <= 1'b0;
      stop_on_flush <= 1'b0;
    end else begin
      if (wr_ctrl) en <= wdata[0];
      if (wr_mode && !en) mode <= wdata[1:0];
      if (wr_trg) trg_cnt <= wdata[CW-1:0];
      if (flush_busy) flush_busy <= 1'b0;
      if (wr_flush) begin
        flush_busy    <= wdata[FLUSH_REQ_BIT];
        stop_on_flush <= wdata[FLUSH_STOP_BIT];
      end
    end
  end
endmodule

// File: rtl/tcb_ram.sv
module tcb_ram #(
  parameter int unsigned DEPTH = 64,
  parameter int unsigned DW    = 32,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/tcb_capture.sv
module tcb_capture
  import tcb_pkg::*;
#(
  parameter int unsigned DEPTH = 64,
  parameter int unsigned CW    = 16,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [1:0]    mode,
  input  logic [CW-1:0] trg_cnt,
  input  logic          arm,
  input  logic          trig_in,
  input  logic          in_valid,
  input  logic          flush_done,
  input  logic          stop_on_flush,
  output logic          cap_on,
  output logic          accept,
  output logic [AW-1:0] wr_ptr,
  output logic          wrapped,
  output logic          triggered,
  output logic          stopped
);
  logic [CW-1:0] remain;
  logic          trig_hit;
  logic          last_slot;

  function automatic logic [AW-1:0] bump(logic [AW-1:0] p);
    return (p == AW'(DEPTH-1)) ? '0 : p + 1'b1;
  endfunction

  assign cap_on    = en && (mode == 2'd0) && !stopped;
  assign accept    = in_valid && cap_on;
  assign trig_hit  = trig_in && cap_on && !triggered;
  assign last_slot = (wr_ptr == AW'(DEPTH-1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr    <= '0;
      wrapped   <= 1'b0;
      triggered <= 1'b0;
      stopped   <= 1'b0;
      remain    <= '0;
    end else if (arm) begin
      wr_ptr    <= '0;
      wrapped   <= 1'b0;
      triggered <= 1'b0;
      stopped   <= 1'b0;
      remain    <= '0;
    end else begin
      if (accept) begin
        wr_ptr <= bump(wr_ptr);
        if (last_slot) wrapped <= 1'b1;
      end
      if (trig_hit) begin
        triggered <= 1'b1;
        remain    <= trg_cnt;
        if (trg_cnt == '0) stopped <= 1'b1;
      end else if (accept && triggered) begin
        remain <= remain - 1'b1;
        if (remain == CW'(1)) stopped <= 1'b1;
      end
      if (flush_done && stop_on_flush && en) stopped <= 1'b1;
    end
  end
endmodule

// File: rtl/tcb_drain.sv
module tcb_drain
  import tcb_pkg::*;
#(
  parameter int unsigned DEPTH = 64,
  localparam int unsigned AW   = $clog2(DEPTH),
  localparam int unsigned LW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          arm,
  input  logic          load,
  input  logic          wrapped,
  input  logic [AW-1:0] wr_ptr,
  input  logic          pop,
  output logic [AW-1:0] rd_ptr,
  output logic          has_data
);
  logic [LW-1:0] left;

  assign has_data = (left != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_ptr <= '0;
      left   <= '0;
    end else if (arm) begin
      rd_ptr <= '0;
      left   <= '0;
    end else if (load) begin
      rd_ptr <= AW'(oldest_index(wrapped, 32'(wr_ptr)));
      left   <= LW'(held_words(wrapped, 32'(wr_ptr), DEPTH));
    end else if (pop && has_data) begin
      rd_ptr <= (rd_ptr == AW'(DEPTH-1)) ? '0 : rd_ptr + 1'b1;
      left   <= left - 1'b1;
    end
  end
endmodule

// File: rtl/trace_capture_buf.sv
module trace_capture_buf
  import tcb_pkg::*;
#(
  parameter int unsigned DEPTH = 64,
  parameter int unsigned CW    = 16,
  parameter int unsigned LANES = 1,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [3:0]        reg_addr,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [WORD_W-1:0] reg_wdata,
  output logic [WORD_W-1:0] reg_rdata,
  input  logic              tr_valid,
  output logic              tr_ready,
  input  logic [WORD_W-1:0] tr_data,
  input  logic              trig_in
);
  logic          en, arm, flush_busy, stop_on_flush;
  logic [1:0]    mode;
  logic [CW-1:0] trg_cnt;
  logic          cap_on, cap_q, accept, wrapped, triggered, stopped;
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic          stop_evt, stat_ready, rd_pop, has_data;
  logic [WORD_W-1:0] ram_q;

  tcb_ctrl_regs #(.CW(CW)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .addr(reg_addr),
    .wdata(reg_wdata), .en(en), .mode(mode), .trg_cnt(trg_cnt),
    .arm(arm), .flush_busy(flush_busy), .stop_on_flush(stop_on_flush)
  );

  tcb_capture #(.DEPTH(DEPTH), .CW(CW)) u_cap (
    .clk(clk), .rst_n(rst_n), .en(en), .mode(mode), .trg_cnt(trg_cnt),
    .arm(arm), .trig_in(trig_in), .in_valid(tr_valid),
    .flush_done(flush_busy), .stop_on_flush(stop_on_flush),
    .cap_on(cap_on), .accept(accept), .wr_ptr(wr_ptr),
    .wrapped(wrapped), .triggered(triggered), .stopped(stopped)
  );

  tcb_ram #(.DEPTH(DEPTH), .DW(WORD_W)) u_ram (
    .clk(clk), .we(accept), .waddr(wr_ptr), .wdata(tr_data),
    .raddr(rd_ptr), .rdata(ram_q)
  );

  tcb_drain #(.DEPTH(DEPTH)) u_drain (
    .clk(clk), .rst_n(rst_n), .arm(arm), .load(stop_evt),
    .wrapped(wrapped), .wr_ptr(wr_ptr), .pop(rd_pop),
    .rd_ptr(rd_ptr), .has_data(has_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cap_q <= 1'b0;
    else        cap_q <= cap_on;
  end

  assign stop_evt   = cap_q && !cap_on;
  assign stat_ready = !cap_on && !cap_q && !flush_busy;
  assign tr_ready   = cap_on;
  assign rd_pop     = reg_rd && (reg_addr == RA_RDATA);

  always_comb begin
    reg_rdata = '0;
    case (reg_addr_e'(reg_addr))
      RA_CTRL:   reg_rdata = {31'd0, en};
      RA_STAT:   reg_rdata = {29'd0, stat_ready, triggered, wrapped};
      RA_SIZE:   reg_rdata = WORD_W'(DEPTH);
      RA_MODE:   reg_rdata = {30'd0, mode};
      RA_TRGCNT: reg_rdata = WORD_W'(trg_cnt);
      RA_RDPTR:  reg_rdata = WORD_W'(rd_ptr);
      RA_WRPTR:  reg_rdata = WORD_W'(wr_ptr);
      RA_RDATA:  reg_rdata = has_data ? ram_q : EMPTY_WORD;
      RA_FLUSH: begin
        reg_rdata[FLUSH_REQ_BIT]  = flush_busy;
        reg_rdata[FLUSH_STOP_BIT] = stop_on_flush;
      end
      RA_DEVID:  reg_rdata = {21'd0, width_code(LANES), 8'd0};
      default:   reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/tcb_checker.sv
module tcb_checker #(
  parameter int unsigned DEPTH = 64,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tr_ready,
  input logic          stopped,
  input logic          flush_busy,
  input logic          stat_ready,
  input logic          accept,
  input logic          arm,
  input logic          wrapped,
  input logic          triggered,
  input logic          stop_evt,
  input logic [AW-1:0] wr_ptr,
  input logic [AW-1:0] rd_ptr
);
  p_stall_when_stopped_r5: assert property (@(posedge clk) disable iff (!rst_n)
    stopped |-> !tr_ready);

  p_flush_selfclear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    flush_busy |=> !flush_busy);

  p_ready_blocks_input_r7: assert property (@(posedge clk) disable iff (!rst_n)
    stat_ready |-> !tr_ready);

  p_wrptr_advance_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !arm) |=>
      wr_ptr == (($past(wr_ptr) == AW'(DEPTH-1)) ? '0 : $past(wr_ptr) + 1'b1));

  p_wrap_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wrapped && !arm) |=> wrapped);

  p_trig_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (triggered && !arm) |=> triggered);

  p_load_oldest_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_evt && !arm) |=> rd_ptr == ($past(wrapped) ? $past(wr_ptr) : '0));
endmodule

bind trace_capture_buf tcb_checker #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .tr_ready(tr_ready), .stopped(stopped),
  .flush_busy(flush_busy), .stat_ready(stat_ready), .accept(accept),
  .arm(arm), .wrapped(wrapped), .triggered(triggered),
  .stop_evt(stop_evt), .wr_ptr(wr_ptr), .rd_ptr(rd_ptr)
);

// File: tb/sim_trace_capture_buf.sv
module sim_trace_capture_buf;
  localparam int D = 64;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [3:0] reg_addr = '0;
  logic reg_wr = 1'b0, reg_rd = 1'b0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic tr_valid = 1'b0, tr_ready, trig_in = 1'b0;
  logic [31:0] tr_data = '0;

  int checks = 0, fails = 0;
  bit done = 0;

  // reference model
  int unsigned mw [D];
  int mwp = 0, mrem = 0, mtc = 0, mmode = 0;
  bit mwrap = 0, mtrig = 0, mstop = 0, men = 0;

  always #2 clk = ~clk;

  trace_capture_buf u0 (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .tr_valid(tr_valid), .tr_ready(tr_ready), .tr_data(tr_data),
    .trig_in(trig_in)
  );

  function automatic bit m_cap();
    return men && mmode == 0 && !mstop;
  endfunction

  function automatic int m_status();
    return (m_cap() ? 0 : 4) | (mtrig ? 2 : 0) | (mwrap ? 1 : 0);
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  // all tasks start and end at a falling edge
  task automatic wr(int a, logic [31:0] d);
    reg_addr = 4'(a); reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(int a, output logic [31:0] d);
    reg_addr = 4'(a); reg_rd = 1'b1;
    #1 d = reg_rdata;
    @(negedge clk); reg_rd = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic enable();
    if (!men) begin
      mwp = 0; mwrap = 0; mtrig = 0; mstop = 0; mrem = 0;
    end
    men = 1;
    wr(0, 1);
  endtask

  task automatic disable_cap();
    men = 0;
    wr(0, 0);
  endtask

  task automatic push(logic [31:0] w);
    logic acc;
    tr_valid = 1'b1; tr_data = w;
    #1 acc = tr_ready;
    checks++;
    if (acc !== m_cap()) begin
      fails++;
      $display("FAIL R3/R5 tr_ready actual=%0b expected=%0b", acc, m_cap());
    end
    @(negedge clk); tr_valid = 1'b0;
    if (m_cap()) begin
      mw[mwp] = w;
      mwp = mwp + 1;
      if (mwp == D) begin mwp = 0; mwrap = 1; end
      if (mtrig) begin
        mrem = mrem - 1;
        if (mrem == 0) mstop = 1;
      end
    end
  endtask

  task automatic trigger();
    trig_in = 1'b1;
    @(negedge clk); trig_in = 1'b0;
    if (m_cap() && !mtrig) begin
      mtrig = 1; mrem = mtc;
      if (mtc == 0) mstop = 1;
    end
  endtask

  // R8, R9: drain and compare against the model
  task automatic drain_check(string tag);
    logic [31:0] v;
    int n = mwrap ? D : mwp;
    int p = mwrap ? mwp : 0;
    rd(5, v); chk({tag, " R8 rdptr"}, v, 32'(p));
    for (int i = 0; i < n; i++) begin
      rd(7, v); chk({tag, " R9 word"}, v, mw[(p + i) % D]);
    end
    rd(7, v); chk({tag, " R9 sentinel"}, v, 32'hFFFF_FFFF);
    rd(7, v); chk({tag, " R9 sentinel hold"}, v, 32'hFFFF_FFFF);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    void'($urandom(32'd1234));
    idle(2); rst_n = 1'b1; idle(1);

    // R1 reset state
    rd(1, v); chk("R1 status", v, 32'h4);
    rd(6, v); chk("R1 wrptr", v, 0);
    rd(5, v); chk("R1 rdptr", v, 0);
    rd(7, v); chk("R1 rdata", v, 32'hFFFF_FFFF);
    checks++; if (tr_ready !== 1'b0) begin fails++; $display("FAIL R1 tr_ready actual=%0b expected=0", tr_ready); end

    // R2 size and width code
    rd(2, v); chk("R2 size", v, D);
    rd(9, v); chk("R2 devid width", (v >> 8) & 7, 2);

    // R3/R4 partial fill, stop by disable
    mtc = 100; wr(4, 100);
    enable();
    for (int i = 0; i < 10; i++) push($urandom);
    rd(6, v); chk("R4 wrptr", v, 10);
    disable_cap(); idle(2);
    rd(1, v); chk("R7 status stopped", v, 32'(m_status()));
    drain_check("partial");

    // R4 wrap
    enable();
    for (int i = 0; i < D + 6; i++) push(32'h1000 + i);
    rd(1, v); chk("R4 wrapped while running", v, 32'h1);
    disable_cap(); idle(2);
    drain_check("wrap");

    // R5 post-trigger count
    mtc = 5; wr(4, 5);
    enable();
    for (int i = 0; i < 3; i++) push($urandom);
    trigger();
    for (int i = 0; i < 10; i++) push($urandom);
    rd(6, v); chk("R5 words kept", v, 8);
    idle(2);
    rd(1, v); chk("R5 R7 status", v, 32'h6);
    drain_check("trig");
    trigger(); // R5 ignored while stopped
    rd(1, v); chk("R5 trigger ignored", v, 32'h6);
    disable_cap();

    // R5 zero count
    mtc = 0; wr(4, 0);
    enable();
    push(32'hAA); trigger(); push(32'hBB);
    idle(2);
    rd(1, v); chk("R5 zero count", v, 32'h6);
    drain_check("trig0");
    disable_cap();

    // R6 flush with stop
    enable();
    for (int i = 0; i < 4; i++) push($urandom);
    wr(8, 32'h1040);
    rd(8, v); chk("R6 flush busy", v, 32'h1040);
    rd(8, v); chk("R6 flush cleared", v, 32'h1000);
    mstop = 1; idle(1);
    rd(1, v); chk("R6 R7 stopped by flush", v, 32'h4);
    push(32'h55);
    drain_check("flush");
    disable_cap();

    // R6 flush without stop
    enable();
    push(32'h1);
    wr(8, 32'h40); idle(2);
    rd(8, v); chk("R6 flush no-stop cleared", v, 0);
    push(32'h2);
    rd(1, v); chk("R6 R7 still running", v, 0);
    disable_cap(); idle(2);
    drain_check("flush_nostop");

    // R10 mode
    enable();
    wr(3, 1);
    rd(3, v); chk("R10 mode write ignored", v, 0);
    disable_cap();
    wr(3, 1); mmode = 1;
    rd(3, v); chk("R10 mode written", v, 1);
    enable();
    push(32'h77);
    rd(6, v); chk("R10 nothing stored", v, 0);
    disable_cap();
    wr(3, 0); mmode = 0;

    // random rounds
    for (int r = 0; r < 8; r++) begin
      int n = $urandom % 160;
      int tp = $urandom % (n + 1);
      bit use_t = ($urandom % 2) == 1;
      mtc = $urandom % 24;
      wr(4, 32'(mtc));
      enable();
      for (int i = 0; i < n; i++) begin
        if (use_t && i == tp) trigger();
        push($urandom);
      end
      rd(6, v); chk("R4 random wrptr", v, 32'(mwp));
      if (m_cap()) disable_cap();
      idle(2);
      rd(1, v); chk("R7 random status", v, 32'(m_status()));
      drain_check("random");
      disable_cap();
    end

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule